// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Power-Down Override

This block is an eight-pin general-purpose I/O port. Software reaches it through a small register interface: a byte offset, a write strobe, 32-bit write data and a combinational 32-bit read path. Each pin is set up as an input, as an output, or as a functional pin. A functional pin carries a 4-bit function-select code to an outside multiplexer. For every pin the port drives an output value, an output enable, a pull enable with a pull direction, and a linear drive-strength level. It also samples the pad input through a synchronizer.

A power-down input moves every pin from its normal settings to a second set of settings. In that set a pin can be forced low, forced high, turned into an input, or made to replay the output value and output enable it had at the moment power-down began. A separate pull selection applies while power-down is active. When power-down ends, the normal settings take over again.

Top module: `gpio_pd_port`

## Requirements
- R1: After reset, every register reads 0 except the pull register, which reads 0x5555. The pins then have output enable 0, output 0, pull enabled in the down direction, drive level 0 and function select 0.
- R2: Registers sit at byte offsets 0x00 (pin mode, 4 bits per pin at [4n+3:4n]), 0x04 (data, 8 bits), 0x08 (pull, 2 bits per pin at [2n+1:2n]), 0x0C (drive), 0x10 (power-down mode) and 0x14 (power-down pull). Each one reads back what was written, and bits above its width read 0.
- R3: A pin-mode nibble of 0000 makes the pin an input (output enable 0, output 0). A nibble of 0001 makes it an output (output enable 1, output equal to its data bit). Any other nibble makes it functional: output enable 0, output 0, and the nibble appears on that pin's function-select field, which is 0 for input and output pins.
- R4: A data read returns the synchronized pad value for input pins, the stored data bit for output pins, and 0 for functional pins. A pad change shows in a read only after two rising clock edges.
- R5: In normal mode the pull code gives: 00 no pull, 01 pull-down, 10 pull-up, 11 no pull. The outputs pull_en and pull_up follow this.
- R6: Drive code 00 gives level 0, 10 gives level 1, 01 gives level 2, and 11 gives level 3. The level is the drive multiplier minus one, 2 bits per pin at [2n+1:2n].
- R7: The override from power-down starts in the cycle after the first rising edge that samples pwr_down high. It ends in the cycle after the first rising edge that samples it low.
- R8: During power-down, mode code 00 drives 0 with output enable 1, 01 drives 1 with output enable 1, and 10 gives output enable 0 with output 0.
- R9: During power-down, mode code 11 replays the output and output enable the pin had in the cycle power-down was sampled. Writes to the mode or data registers made during power-down do not change these values, and each entry captures the values afresh.
- R10: During power-down, the power-down pull register decides pull_en and pull_up, using the R5 encoding.
- R11: A read from any offset other than the six listed in R2, including offsets that are not multiples of 4, returns 0. A write to such an offset changes no register and no pin output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 5 | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pwr_down | input | 1 | Power-down request |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pin output values |
| pad_oe | output | 8 | Pin output enables |
| pull_en | output | 8 | Pull enable per pin |
| pull_up | output | 8 | Pull direction (1 = up) per pin |
| drv_lvl | output | 16 | Linear drive level, 2 bits per pin |
| func_sel | output | 32 | Function-select code, 4 bits per pin |

## Verification
The bench covers the edge cases in the pin mapping. A drive decoder that treated the code as linear would give the wrong level for codes 01 and 10. A data read that passed the pad through for functional pins would show the pad's ones where zeros are expected. A synchronizer with the wrong depth would report the pad one cycle early or late. For power-down, the bench checks the one-cycle delay on entry and on exit. It rewrites the mode and data registers while power-down is held, and a design that replayed live values instead of captured ones would let those writes through. It then enters power-down a second time with different output values, which catches a capture taken only once. Writes to unmapped and misaligned offsets are followed by readbacks, so a loose address decoder would be seen corrupting a register.

// File: rtl/gpio_pd_pkg.sv
package gpio_pd_pkg;

    localparam int NPIN   = 8;
    localparam int MODE_W = 4;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 32;
    localparam int CODE_W = 2;
    localparam int MODE_BITS = NPIN * MODE_W;
    localparam int CODE_BITS = NPIN * CODE_W;

    localparam logic [ADDR_W-1:0] OFF_MODE = 5'h00;
    localparam logic [ADDR_W-1:0] OFF_DATA = 5'h04;
    localparam logic [ADDR_W-1:0] OFF_PULL = 5'h08;
    localparam logic [ADDR_W-1:0] OFF_DRV  = 5'h0C;
    localparam logic [ADDR_W-1:0] OFF_PDM  = 5'h10;
    localparam logic [ADDR_W-1:0] OFF_PDP  = 5'h14;

    localparam logic [MODE_W-1:0] MODE_IN  = 4'h0;
    localparam logic [MODE_W-1:0] MODE_OUT = 4'h1;

    typedef enum logic [CODE_W-1:0] {
        PULL_NONE = 2'b00,
        PULL_DOWN = 2'b01,
        PULL_UPW  = 2'b10,
        PULL_RSVD = 2'b11
    } pull_code_e;

    typedef enum logic [CODE_W-1:0] {
        PDM_LOW  = 2'b00,
        PDM_HIGH = 2'b01,
        PDM_IN   = 2'b10,
        PDM_HOLD = 2'b11
    } pdm_code_e;

    localparam logic [CODE_BITS-1:0] PULL_RESET = {NPIN{PULL_DOWN}};

    typedef struct packed {
        logic [MODE_BITS-1:0] mode;
        logic [NPIN-1:0]      data;
        logic [CODE_BITS-1:0] pull;
        logic [CODE_BITS-1:0] drv;
        logic [CODE_BITS-1:0] pdm;
        logic [CODE_BITS-1:0] pdp;
    } port_regs_t;

    function automatic logic [1:0] pull_decode(input logic [CODE_W-1:0] code);
        // returns {enable, up}
        case (pull_code_e'(code))
            PULL_DOWN: return 2'b10;
            PULL_UPW:  return 2'b11;
            default:   return 2'b00;
        endcase
    endfunction

endpackage

// File: rtl/gpio_pd_sync.sv
module gpio_pd_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        for (int s = 0; s < STAGES; s++) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_d[s];
        end
    end

    assign dout = stage_q[STAGES-1];

    generate
        if (STAGES == 2) begin : g_chk
            logic [1:0] warm_q;
            always_ff @(posedge clk) begin
                if (!rst_n)            warm_q <= '0;
                else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
            end
            // R4: pad reaches the read path two edges later
            a_r4_sync_latency: assert property (@(posedge clk) disable iff (!rst_n)
                (warm_q == 2'd2) |-> (dout == $past(din, 2)));
        end
    endgenerate

endmodule

// File: rtl/gpio_pd_regs.sv
module gpio_pd_regs
    import gpio_pd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NPIN-1:0]   pad_sync,
    output logic [DATA_W-1:0] rdata,
    output port_regs_t        regs
);
    localparam port_regs_t RESET_VAL = '{
        mode: '0, data: '0, pull: PULL_RESET, drv: '0, pdm: '0, pdp: '0
    };

    port_regs_t regs_d, regs_q;
    logic [NPIN-1:0] data_rd;
    logic            mapped;

    always_comb begin
        regs_d = regs_q;
        if (wr) begin
            case (addr)
                OFF_MODE: regs_d.mode = wdata[MODE_BITS-1:0];
                OFF_DATA: regs_d.data = wdata[NPIN-1:0];
                OFF_PULL: regs_d.pull = wdata[CODE_BITS-1:0];
                OFF_DRV:  regs_d.drv  = wdata[CODE_BITS-1:0];
                OFF_PDM:  regs_d.pdm  = wdata[CODE_BITS-1:0];
                OFF_PDP:  regs_d.pdp  = wdata[CODE_BITS-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= RESET_VAL;
        else        regs_q <= regs_d;
    end

    always_comb begin
        for (int i = 0; i < NPIN; i++) begin
            case (regs_q.mode[i*MODE_W +: MODE_W])
                MODE_IN:  data_rd[i] = pad_sync[i];
                MODE_OUT: data_rd[i] = regs_q.data[i];
                default:  data_rd[i] = 1'b0;
            endcase
        end
    end

    always_comb begin
        rdata  = '0;
        mapped = 1'b1;
        case (addr)
            OFF_MODE: rdata[MODE_BITS-1:0] = regs_q.mode;
            OFF_DATA: rdata[NPIN-1:0]      = data_rd;
            OFF_PULL: rdata[CODE_BITS-1:0] = regs_q.pull;
            OFF_DRV:  rdata[CODE_BITS-1:0] = regs_q.drv;
            OFF_PDM:  rdata[CODE_BITS-1:0] = regs_q.pdm;
            OFF_PDP:  rdata[CODE_BITS-1:0] = regs_q.pdp;
            default:  mapped = 1'b0;
        endcase
    end

    assign regs = regs_q;

    // R11: a write to an unmapped offset leaves all registers untouched
    a_r11_unmapped_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !mapped) |=> $stable(regs_q));

    // R11: unmapped reads return zero
    a_r11_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> (rdata == '0));

endmodule

// File: rtl/gpio_pd_seq.sv
module gpio_pd_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_down,
    output logic pd_act,
    output logic pd_entry
);
    typedef struct packed {
        logic active;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d        = seq_q;
        seq_d.active = pwr_down;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign pd_act   = seq_q.active;
    assign pd_entry = pwr_down && !seq_q.active;

endmodule

// File: rtl/gpio_pd_pin.sv
module gpio_pd_pin
    import gpio_pd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic              data,
    input  logic [CODE_W-1:0] pull,
    input  logic [CODE_W-1:0] drv,
    input  logic [CODE_W-1:0] pdm,
    input  logic [CODE_W-1:0] pdp,
    input  logic              pd_act,
    input  logic              pd_entry,
    output logic              out,
    output logic              oe,
    output logic              pen,
    output logic              pup,
    output logic [CODE_W-1:0] lvl,
    output logic [MODE_W-1:0] fsel
);
    typedef struct packed {
        logic out;
        logic oe;
    } hold_t;

    hold_t hold_d, hold_q;
    logic  nrm_out, nrm_oe;
    logic [1:0] pull_dec;

    always_comb begin
        nrm_oe  = (mode == MODE_OUT);
        nrm_out = nrm_oe && data;

        hold_d = hold_q;
        if (pd_entry) begin
            hold_d.out = nrm_out;
            hold_d.oe  = nrm_oe;
        end

        if (pd_act) begin
            case (pdm_code_e'(pdm))
                PDM_LOW:  begin out = 1'b0;       oe = 1'b1;      end
                PDM_HIGH: begin out = 1'b1;       oe = 1'b1;      end
                PDM_IN:   begin out = 1'b0;       oe = 1'b0;      end
                default:  begin out = hold_q.out; oe = hold_q.oe; end
            endcase
            pull_dec = pull_decode(pdp);
        end else begin
            out      = nrm_out;
            oe       = nrm_oe;
            pull_dec = pull_decode(pull);
        end
        pen = pull_dec[1];
        pup = pull_dec[0];

        case (drv)
            2'b00:   lvl = 2'd0;
            2'b10:   lvl = 2'd1;
            2'b01:   lvl = 2'd2;
            default: lvl = 2'd3;
        endcase

        fsel = (mode == MODE_IN || mode == MODE_OUT) ? '0 : mode;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    // R5: a pull direction is only meaningful with pull enabled
    a_r5_up_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        pup |-> pen);

endmodule

// File: rtl/gpio_pd_port.sv
module gpio_pd_port
    import gpio_pd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              pwr_down,
    input  logic [NPIN-1:0]   pad_in,
    output logic [NPIN-1:0]   pad_out,
    output logic [NPIN-1:0]   pad_oe,
    output logic [NPIN-1:0]   pull_en,
    output logic [NPIN-1:0]   pull_up,
    output logic [CODE_BITS-1:0] drv_lvl,
    output logic [MODE_BITS-1:0] func_sel
);
    port_regs_t      regs;
    logic [NPIN-1:0] pad_sync;
    logic            pd_act, pd_entry;

    gpio_pd_sync #(.W(NPIN), .STAGES(2)) i_sync (
        .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(pad_sync)
    );

    gpio_pd_regs i_regs (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr),
        .wdata(reg_wdata), .pad_sync(pad_sync), .rdata(reg_rdata), .regs(regs)
    );

    gpio_pd_seq i_seq (
        .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down),
        .pd_act(pd_act), .pd_entry(pd_entry)
    );

    generate
        for (genvar i = 0; i < NPIN; i++) begin : g_pin
            gpio_pd_pin i_pin (
                .clk      (clk),
                .rst_n    (rst_n),
                .mode     (regs.mode[i*MODE_W +: MODE_W]),
                .data     (regs.data[i]),
                .pull     (regs.pull[i*CODE_W +: CODE_W]),
                .drv      (regs.drv[i*CODE_W +: CODE_W]),
                .pdm      (regs.pdm[i*CODE_W +: CODE_W]),
                .pdp      (regs.pdp[i*CODE_W +: CODE_W]),
                .pd_act   (pd_act),
                .pd_entry (pd_entry),
                .out      (pad_out[i]),
                .oe       (pad_oe[i]),
                .pen      (pull_en[i]),
                .pup      (pull_up[i]),
                .lvl      (drv_lvl[i*CODE_W +: CODE_W]),
                .fsel     (func_sel[i*MODE_W +: MODE_W])
            );

            // R3: an output pin drives the bit just written to the data register
            a_r3_out_follows_data: assert property (@(posedge clk) disable iff (!rst_n)
                (reg_wr && reg_addr == OFF_DATA && !pwr_down && !pd_act &&
                 regs.mode[i*MODE_W +: MODE_W] == MODE_OUT)
                |=> (pad_oe[i] && pad_out[i] == $past(reg_wdata[i])));

            // R8: forced-low code drives 0 once power-down is in effect
            a_r8_force_low: assert property (@(posedge clk) disable iff (!rst_n)
                (pwr_down && regs.pdm[i*CODE_W +: CODE_W] == PDM_LOW &&
                 !(reg_wr && reg_addr == OFF_PDM))
                |=> (pad_oe[i] && !pad_out[i]));

            // R9: hold code keeps the pin frozen while power-down persists
            a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
                (pd_act && $past(pd_act) &&
                 regs.pdm[i*CODE_W +: CODE_W] == PDM_HOLD &&
                 $past(regs.pdm[i*CODE_W +: CODE_W]) == PDM_HOLD)
                |-> ($stable(pad_out[i]) && $stable(pad_oe[i])));
        end
    endgenerate

endmodule

// File: tb/test_gpio_pd_port.sv
module test_gpio_pd_port;
    import gpio_pd_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [ADDR_W-1:0] reg_addr;
    logic              reg_wr;
    logic [DATA_W-1:0] reg_wdata;
    logic [DATA_W-1:0] reg_rdata;
    logic              pwr_down;
    logic [NPIN-1:0]   pad_in, pad_out, pad_oe, pull_en, pull_up;
    logic [CODE_BITS-1:0] drv_lvl;
    logic [MODE_BITS-1:0] func_sel;

    always #10 clk = ~clk;

    gpio_pd_port i_gpio_pd_port (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwr_down(pwr_down),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pull_en(pull_en),
        .pull_up(pull_up), .drv_lvl(drv_lvl), .func_sel(func_sel)
    );

    localparam int S_RD = 0, S_OUT = 1, S_OE = 2, S_PEN = 3, S_PUP = 4, S_DRV = 5, S_FSEL = 6;

    typedef struct {
        int          sel;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t sb[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    function automatic logic [31:0] observe(int sel);
        case (sel)
            S_RD:    return reg_rdata;
            S_OUT:   return {24'b0, pad_out};
            S_OE:    return {24'b0, pad_oe};
            S_PEN:   return {24'b0, pull_en};
            S_PUP:   return {24'b0, pull_up};
            S_DRV:   return {16'b0, drv_lvl};
            default: return func_sel;
        endcase
    endfunction

    // monitor: compares queued expectations shortly after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb.size() > 0) begin
                item_t it;
                logic [31:0] got;
                it  = sb.pop_front();
                got = observe(it.sel);
                n_cmp++;
                if (got !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s sel=%0d: got %h expected %h", it.req, it.sel, got, it.exp);
                end
            end
        end
    end

    task automatic expect_v(int sel, logic [31:0] exp, string req);
        item_t it;
        it.sel = sel; it.exp = exp; it.req = req;
        sb.push_back(it);
    endtask

    task automatic pins(logic [7:0] o, logic [7:0] e, string req);
        expect_v(S_OUT, {24'b0, o}, req);
        expect_v(S_OE,  {24'b0, e}, req);
    endtask

    task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(logic [ADDR_W-1:0] a, logic [31:0] exp, string req);
        reg_addr = a;
        expect_v(S_RD, exp, req);
        @(negedge clk);
    endtask

    task automatic finish_run();
        @(negedge clk);
        #5;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
        pwr_down = 1'b0; pad_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        pins(8'h00, 8'h00, "R1");
        expect_v(S_PEN, 32'hFF, "R1");
        expect_v(S_PUP, 32'h00, "R1");
        expect_v(S_DRV, 32'h0, "R1");
        expect_v(S_FSEL, 32'h0, "R1");
        rd(OFF_MODE, 32'h0, "R1");
        rd(OFF_DATA, 32'h0, "R1");
        rd(OFF_PULL, 32'h5555, "R1");
        rd(OFF_DRV,  32'h0, "R1");
        rd(OFF_PDM,  32'h0, "R1");
        rd(OFF_PDP,  32'h0, "R1");

        // R4 synchronizer latency (all pins inputs)
        reg_addr = OFF_DATA;
        pad_in   = 8'hA5;
        expect_v(S_RD, 32'h0, "R4");
        @(negedge clk);
        expect_v(S_RD, 32'h0, "R4");
        @(negedge clk);
        expect_v(S_RD, 32'hA5, "R4");
        @(negedge clk);

        // R2/R3 pin modes: pins 0,1,4,7 out; 3,6 in; 2 func 3; 5 func F
        wr(OFF_MODE, 32'h10F10311);
        rd(OFF_MODE, 32'h10F10311, "R2");
        wr(OFF_DATA, 32'hFFFFFF5A);
        pins(8'h12, 8'h93, "R3");
        expect_v(S_FSEL, 32'h00F00300, "R3");
        rd(OFF_DATA, 32'h12, "R4");
        pad_in = 8'h48;
        @(negedge clk);
        @(negedge clk);
        rd(OFF_DATA, 32'h5A, "R4");

        // R5 pull decode, R6 drive decode
        wr(OFF_PULL, 32'hFFFFC6E4);
        rd(OFF_PULL, 32'hC6E4, "R2");
        expect_v(S_PEN, 32'h36, "R5");
        expect_v(S_PUP, 32'h14, "R5");
        wr(OFF_DRV, 32'hC6E4);
        rd(OFF_DRV, 32'hC6E4, "R2");
        expect_v(S_DRV, 32'hC9D8, "R6");

        // R11 unmapped and misaligned offsets
        wr(5'h18, 32'hFFFFFFFF);
        wr(5'h01, 32'hFFFFFFFF);
        wr(5'h1C, 32'hFFFFFFFF);
        pins(8'h12, 8'h93, "R11");
        rd(5'h18, 32'h0, "R11");
        rd(5'h01, 32'h0, "R11");
        rd(OFF_MODE, 32'h10F10311, "R11");
        rd(OFF_PULL, 32'hC6E4, "R11");
        rd(OFF_DRV,  32'hC6E4, "R11");
        rd(OFF_DATA, 32'h5A, "R11");

        // power-down settings
        wr(OFF_PDM, 32'h7E4F);
        wr(OFF_PDP, 32'hD556);
        rd(OFF_PDM, 32'h7E4F, "R2");
        rd(OFF_PDP, 32'hD556, "R2");
        pins(8'h12, 8'h93, "R7");

        // R7 entry delay, R8/R9/R10 overrides
        pwr_down = 1'b1;
        pins(8'h12, 8'h93, "R7");
        @(negedge clk);
        pins(8'h8A, 8'h8F, "R8");
        expect_v(S_PEN, 32'h7F, "R10");
        expect_v(S_PUP, 32'h01, "R10");
        expect_v(S_DRV, 32'hC9D8, "R6");
        wr(OFF_DATA, 32'h0);
        wr(OFF_MODE, 32'h0);
        pins(8'h8A, 8'h8F, "R9");

        // R7 exit delay
        pwr_down = 1'b0;
        pins(8'h8A, 8'h8F, "R7");
        @(negedge clk);
        pins(8'h00, 8'h00, "R7");
        expect_v(S_PEN, 32'h36, "R5");
        expect_v(S_PUP, 32'h14, "R5");

        // R9 fresh capture on re-entry
        wr(OFF_MODE, 32'h10F10311);
        wr(OFF_DATA, 32'hFF);
        pins(8'h93, 8'h93, "R3");
        pwr_down = 1'b1;
        @(negedge clk);
        pins(8'h8B, 8'h8F, "R9");
        pwr_down = 1'b0;
        @(negedge clk);
        @(negedge clk);

        done = 1'b1;
        finish_run();
    end

endmodule